// File: doc/BRIEF.md
# On/Off Cycle Gate with Protections

This block decides, once per switching cycle, whether a power switch conducts. Regulation is on/off, not pulse-width modulated. At the cycle-start strobe the feedback comparator bit is sampled. If it is high and every protection is clear, the gate turns on. The gate then stays on until one of three things happens: the maximum-duty window closes, the current-limit comparator trips after a blanking interval, or a protection fault appears. Once the gate is off, it stays off until the next cycle-start strobe.

Three protection mechanisms are combined into one permit, and each has its own kind of exit. The rail undervoltage lockout is hysteretic: it is set by a "rail low" flag and cleared only by a "rail ready" flag. The overvoltage latch needs two conditions at once to set, the rail above the shunt level and excess shunt current, and it clears only when the rail collapses. The thermal shutdown is hysteretic between a "hot" flag and a "cooled" flag. The oscillator, the comparators and the analog thresholds are outside this block; it sees only their digital outputs.

Top module: `onoff_gate`

## Requirements
- R1: After reset `gateOn` is low and the undervoltage lockout is engaged, so no cycle-start turns the gate on until `railReady` has been seen high.
- R2: On a clock edge where `cycleStart` is high, the gate turns on at that edge if `fbEnable`, `dutyWin` and all protections are clear (low-fault). If `fbEnable` is low at that edge, the gate stays off.
- R3: `fbEnable` is looked at only on cycle-start edges. A fall during the on-time does not end it, and a rise after the cycle start does not start the gate.
- R4: While the gate is on, `dutyWin` low turns it off at the next edge. The gate stays off until a later cycle-start edge.
- R5: Once blanking has elapsed, `curLimit` high while the gate is on turns it off at the next edge. The gate stays off for the rest of the cycle, even after `curLimit` drops.
- R6: `curLimit` has no effect on the first BLANK_CYCLES clock edges that follow the turn-on edge.
- R7: `railLow` engages the undervoltage lockout. The lockout holds, even after `railLow` drops, until `railReady` is high. If both flags are high, `railLow` wins.
- R8: The overvoltage latch sets only when `railOver` and `shuntExcess` are high on the same edge; `railOver` alone does nothing. Once set, the latch holds until `railCollapsed` is high, and clearing has priority over setting.
- R9: `tempHot` engages the thermal shutdown. The shutdown holds until `tempCooled` is high. If both flags are high, `tempHot` wins.
- R10: A protection fault that arrives during an on-time ends it. Gate-off follows the fault input within two clock edges, with no wait for the cycle to end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cycleStart | input | 1 | One-clock strobe marking the start of a switching cycle |
| dutyWin | input | 1 | High while the maximum-duty window is open |
| fbEnable | input | 1 | Feedback comparator: high requests switching this cycle |
| curLimit | input | 1 | Current-limit comparator trip |
| railLow | input | 1 | Supply rail below the lower lockout threshold |
| railReady | input | 1 | Supply rail at the upper lockout threshold |
| railOver | input | 1 | Supply rail above the shunt level |
| shuntExcess | input | 1 | Shunt current above its limit |
| railCollapsed | input | 1 | Supply rail pulled below the latch-reset level |
| tempHot | input | 1 | Die above the thermal trip point |
| tempCooled | input | 1 | Die cooled by the hysteresis amount |
| gateOn | output | 1 | Gate drive to the power switch |

## Verification
Every protection flag and the blanking counter act only through `gateOn`, so a wrong internal state appears there quickly. A stuck or wrongly cleared protection flag shows up at the next cycle-start edge: the gate either fails to rise or rises when it should not. A blanking counter that is off by one moves the current-limit turn-off by exactly one edge. The bench therefore samples on both sides of the blanking boundary. For each protection it also checks that the gate stays off after the fault input drops, and that it returns only after the specific exit flag.

// File: rtl/onoff_gate_pkg.sv
package onoff_gate_pkg;
  typedef struct packed {
    logic turnOn;
    logic turnOff;
  } gateStrobe_t;
endpackage

// File: rtl/onoff_gate_ctrl.sv
module onoff_gate_ctrl
  import onoff_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cycleStart,
  input  logic        dutyWin,
  input  logic        fbEnable,
  input  logic        curLimit,
  input  logic        railLow,
  input  logic        railReady,
  input  logic        railOver,
  input  logic        shuntExcess,
  input  logic        railCollapsed,
  input  logic        tempHot,
  input  logic        tempCooled,
  input  logic        gateOn,
  input  logic        blanking,
  output gateStrobe_t strobe
);
  logic uvLock, ovLatch, thermLock, protOk;

  // undervoltage lockout: engaged from reset, hysteretic
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          uvLock <= 1'b1;
    else if (railLow)   uvLock <= 1'b1;
    else if (railReady) uvLock <= 1'b0;
  end

  // overvoltage latch: clear has priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          ovLatch <= 1'b0;
    else if (railCollapsed)             ovLatch <= 1'b0;
    else if (railOver && shuntExcess)   ovLatch <= 1'b1;
  end

  // thermal shutdown: hot has priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           thermLock <= 1'b0;
    else if (tempHot)    thermLock <= 1'b1;
    else if (tempCooled) thermLock <= 1'b0;
  end

  assign protOk = !uvLock && !ovLatch && !thermLock;

  always_comb begin
    strobe.turnOn  = cycleStart && fbEnable && dutyWin && protOk;
    strobe.turnOff = gateOn && (!dutyWin || !protOk || (curLimit && !blanking));
  end

  p_start_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOn) |-> $past(cycleStart && fbEnable));
  p_duty_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    !dutyWin |=> !gateOn);
  p_blank_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (gateOn && blanking && dutyWin && protOk) |=> gateOn);
  p_uv_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (uvLock && !railReady) |=> uvLock);
  p_ov_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ovLatch && !railCollapsed) |=> ovLatch);
  p_therm_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (thermLock && !tempCooled) |=> thermLock);
  p_fault_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    !protOk |=> !gateOn);
endmodule

// File: rtl/onoff_gate_dp.sv
module onoff_gate_dp
  import onoff_gate_pkg::*;
#(
  parameter int BLANK_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  gateStrobe_t strobe,
  output logic        gateOn,
  output logic        blanking
);
  localparam int CW = $clog2(BLANK_CYCLES + 1);
  localparam logic [CW-1:0] BLANK_LIM = CW'(BLANK_CYCLES);

  logic [CW-1:0] blankCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateOn   <= 1'b0;
      blankCnt <= '0;
    end else if (strobe.turnOn) begin
      gateOn   <= 1'b1;
      blankCnt <= '0;
    end else begin
      if (strobe.turnOff) gateOn <= 1'b0;
      if (gateOn && blankCnt < BLANK_LIM) blankCnt <= blankCnt + 1'b1;
    end
  end

  assign blanking = gateOn && (blankCnt < BLANK_LIM);

  p_blank_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    blankCnt <= BLANK_LIM);
  p_restart_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.turnOn |=> (blankCnt == '0));
endmodule

// File: rtl/onoff_gate.sv
module onoff_gate
  import onoff_gate_pkg::*;
#(
  parameter int BLANK_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic cycleStart,
  input  logic dutyWin,
  input  logic fbEnable,
  input  logic curLimit,
  input  logic railLow,
  input  logic railReady,
  input  logic railOver,
  input  logic shuntExcess,
  input  logic railCollapsed,
  input  logic tempHot,
  input  logic tempCooled,
  output logic gateOn
);
  gateStrobe_t strobe;
  logic        blanking;

  onoff_gate_ctrl uCtrl (
    .clk, .rstN, .cycleStart, .dutyWin, .fbEnable, .curLimit,
    .railLow, .railReady, .railOver, .shuntExcess, .railCollapsed,
    .tempHot, .tempCooled, .gateOn, .blanking, .strobe
  );

  onoff_gate_dp #(.BLANK_CYCLES(BLANK_CYCLES)) uDp (
    .clk, .rstN, .strobe, .gateOn, .blanking
  );
endmodule

// File: tb/tb_onoff_gate.sv
module tb_onoff_gate;
  localparam int BLANK = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleStart = 0, dutyWin = 1, fbEnable = 0, curLimit = 0;
  logic railLow = 0, railReady = 0, railOver = 0, shuntExcess = 0;
  logic railCollapsed = 0, tempHot = 0, tempCooled = 0;
  logic gateOn;
  int checks = 0, failures = 0;
  bit done = 0;

  onoff_gate #(.BLANK_CYCLES(BLANK)) dut (.*);

  always #2.5 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect1(input logic exp, input string req);
    checks++;
    if (gateOn !== exp) begin
      failures++;
      $display("FAIL %s gateOn actual=%b expected=%b at %0t", req, gateOn, exp, $time);
    end
  endtask

  task automatic startCycle(input logic fb);
    fbEnable = fb; cycleStart = 1; step(1); cycleStart = 0;
  endtask

  task automatic endCycle();
    dutyWin = 0; step(1); dutyWin = 1;
  endtask

  task automatic pulseReady();
    railReady = 1; step(1); railReady = 0;
  endtask

  task automatic t_reset();
    expect1(1'b0, "R1 reset");
    startCycle(1); expect1(1'b0, "R1 locked before ready");
    endCycle();
    pulseReady();
  endtask

  task automatic t_feedback();
    startCycle(1); expect1(1'b1, "R2 start with fb high");
    fbEnable = 0; step(3); expect1(1'b1, "R3 fb fall mid-cycle ignored");
    endCycle(); expect1(1'b0, "R4 duty end turns off");
    fbEnable = 1; step(3); expect1(1'b0, "R4 stays off until next start (R3 rise ignored)");
    startCycle(0); expect1(1'b0, "R2 fb low at start");
    fbEnable = 1; step(2); expect1(1'b0, "R3 fb rise after start ignored");
  endtask

  task automatic t_blank();
    startCycle(1); expect1(1'b1, "R6 on");
    curLimit = 1; step(BLANK); expect1(1'b1, "R6 curLimit blanked");
    step(1); expect1(1'b0, "R5 curLimit after blanking");
    curLimit = 0; step(2); expect1(1'b0, "R5 stays off rest of cycle");
    endCycle();
  endtask

  task automatic t_uv();
    startCycle(1); expect1(1'b1, "R7 on");
    railLow = 1; step(2); expect1(1'b0, "R10 uv fault ends on-time");
    railLow = 0; endCycle();
    startCycle(1); expect1(1'b0, "R7 still locked after railLow drop");
    endCycle();
    railLow = 1; railReady = 1; step(1); railLow = 0; railReady = 0;
    startCycle(1); expect1(1'b0, "R7 railLow wins over railReady");
    endCycle();
    pulseReady();
    startCycle(1); expect1(1'b1, "R7 released by railReady");
    endCycle();
  endtask

  task automatic t_ov();
    startCycle(1);
    railOver = 1; step(3); expect1(1'b1, "R8 railOver alone no effect");
    shuntExcess = 1; step(1); railOver = 0; shuntExcess = 0; step(1);
    expect1(1'b0, "R10 ov latch ends on-time");
    endCycle();
    pulseReady();
    startCycle(1); expect1(1'b0, "R8 latch holds");
    endCycle();
    railOver = 1; shuntExcess = 1; railCollapsed = 1; step(1);
    railOver = 0; shuntExcess = 0; railCollapsed = 0;
    startCycle(1); expect1(1'b1, "R8 collapse clears latch with priority");
    endCycle();
  endtask

  task automatic t_therm();
    startCycle(1);
    tempHot = 1; step(2); expect1(1'b0, "R9 hot ends on-time");
    tempHot = 0; endCycle();
    startCycle(1); expect1(1'b0, "R9 holds until cooled");
    endCycle();
    tempHot = 1; tempCooled = 1; step(1); tempHot = 0; tempCooled = 0;
    startCycle(1); expect1(1'b0, "R9 hot wins over cooled");
    endCycle();
    tempCooled = 1; step(1); tempCooled = 0;
    startCycle(1); expect1(1'b1, "R9 released by cooled");
    endCycle();
  endtask

  initial begin
    step(2); rstN = 1; step(1);
    t_reset();
    t_feedback();
    t_blank();
    t_uv();
    t_ov();
    t_therm();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule